// File: doc/BRIEF.md
# Multi-Issue Bundle Legality Checker

This block takes one wide instruction bundle per clock and decides whether it may be issued as a unit. A bundle is a fixed row of operation slots. Each slot has a valid bit, a 3-bit engine class, one destination scratch address and two source scratch addresses, and each operand has its own enable. The checker counts the live operations of each engine class against that class's quota. It also looks for operand overlaps between slots that would make a same-cycle issue wrong. The result appears one cycle later, as an accept bit plus one flag per kind of violation.

Slot order is program order: slot 0 comes first. All reads in a bundle see scratch contents as they were before the bundle, and all writes commit together at its end. Under this rule a later slot that reads what an earlier slot writes would get stale data, so the bundle is rejected. Two writes to one word give an undefined result, so that bundle is rejected too. A later slot that writes what an earlier slot reads is harmless here, so it is only reported.

Vector-ALU operands are spans of 8 consecutive scratch words starting at the given base. Every other operand is a single word. The scratch space has 1536 words.

Top module: `vliw_bundle_check`

## Requirements
- R1: After reset, resValid, accept, overLimit, rawHit, wawHit, warHit, fieldBad and opCount are all zero.
- R2: A bundle presented with bundleValid high at a rising edge produces its result on the outputs after that edge, with resValid high for that one cycle. When bundleValid is low, resValid is low in the next cycle and every result output holds its previous value.
- R3: Slot i occupies bits [i*W +: W] of each flattened slot port. opCount equals the number of slots whose slotValid bit is set. A slot with slotValid low affects no count and no flag, and an operand whose enable is low takes part in no conflict or range test.
- R4: The class codes are 0 scalar ALU, 1 vector ALU, 2 load, 3 store and 4 flow, and the default quotas are 12, 6, 2, 2 and 1. overLimit bit k is set exactly when more valid slots carry class code k than the quota of class k allows.
- R5: rawHit is set when an enabled source of a slot overlaps the enabled destination of a lower-numbered valid slot.
- R6: wawHit is set when the enabled destinations of two different valid slots overlap.
- R7: warHit is set when the enabled destination of a slot overlaps an enabled source of a lower-numbered valid slot. warHit alone never clears accept.
- R8: Slots that only share source addresses, and a slot whose own source equals its own destination, raise no conflict flag.
- R9: Every operand of a class-1 slot covers base through base+7. All other operands cover one word. Overlap is a range test on these spans.
- R10: fieldBad is set when a valid slot carries a class code of 5, 6 or 7, or when an enabled operand's span reaches past word 1535.
- R11: accept is set exactly when overLimit is zero and rawHit, wawHit and fieldBad are all clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bundleValid | input | 1 | A bundle is present this cycle |
| slotValid | input | NUM_SLOTS | Per-slot valid bit |
| slotClass | input | 3*NUM_SLOTS | Per-slot engine class code |
| slotDst | input | ADDR_W*NUM_SLOTS | Per-slot destination base address |
| slotDstEn | input | NUM_SLOTS | Destination in use |
| slotSrcA | input | ADDR_W*NUM_SLOTS | Per-slot first source base address |
| slotSrcAEn | input | NUM_SLOTS | First source in use |
| slotSrcB | input | ADDR_W*NUM_SLOTS | Per-slot second source base address |
| slotSrcBEn | input | NUM_SLOTS | Second source in use |
| resValid | output | 1 | Result registers hold a new bundle's outcome |
| accept | output | 1 | Bundle may issue |
| overLimit | output | 5 | Per-class quota exceeded, bit index = class code |
| rawHit | output | 1 | Later slot reads an earlier slot's write |
| wawHit | output | 1 | Two slots write a common word |
| warHit | output | 1 | Later slot writes an earlier slot's read |
| fieldBad | output | 1 | Illegal class code or address span |
| opCount | output | clog2(NUM_SLOTS+1) | Valid operations in the bundle |

## Verification
The bench builds the checker with 16 slots and keeps the default quotas, vector length and 1536-word scratch size. Sixteen slots are enough to put 13 scalar operations in one bundle, one past the largest quota, so every class's quota can be exceeded by exactly one. Keeping the scratch size puts the top-of-space edge within reach: a vector at base 1528 ends on word 1535 and passes, while a base of 1529 fails. The vector span edges are exercised at base+7 and base+8 against scalar operands.

// File: rtl/vliw_chk_pkg.sv
package vliw_chk_pkg;

  localparam int CLS_W       = 3;
  localparam int NUM_CLASSES = 5;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU   = 3'd0,
    CLS_VALU  = 3'd1,
    CLS_LOAD  = 3'd2,
    CLS_STORE = 3'd3,
    CLS_FLOW  = 3'd4
  } engClass_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;
  } chkStrobe_t;

endpackage

// File: rtl/vliw_slot_counter.sv
module vliw_slot_counter
  import vliw_chk_pkg::*;
#(
  parameter int NUM_SLOTS = 23,
  parameter int CNT_W     = 5,
  parameter int LIM_ALU   = 12,
  parameter int LIM_VALU  = 6,
  parameter int LIM_LOAD  = 2,
  parameter int LIM_STORE = 2,
  parameter int LIM_FLOW  = 1
) (
  input  logic [NUM_SLOTS-1:0]       slotValid,
  input  logic [NUM_SLOTS*CLS_W-1:0] slotClass,
  output logic [CNT_W-1:0]           totalCount,
  output logic [NUM_CLASSES-1:0]     overLimit,
  output logic                       classBad
);

  localparam int LIMITS [NUM_CLASSES] = '{LIM_ALU, LIM_VALU, LIM_LOAD, LIM_STORE, LIM_FLOW};

  logic [CNT_W-1:0] perClass [NUM_CLASSES];

  always_comb begin
    totalCount = '0;
    classBad   = 1'b0;
    for (int c = 0; c < NUM_CLASSES; c++) perClass[c] = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slotValid[s]) begin
        totalCount = totalCount + CNT_W'(1);
        if (slotClass[s*CLS_W +: CLS_W] >= CLS_W'(NUM_CLASSES)) classBad = 1'b1;
        for (int c = 0; c < NUM_CLASSES; c++) begin
          if (slotClass[s*CLS_W +: CLS_W] == CLS_W'(c)) perClass[c] = perClass[c] + CNT_W'(1);
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_quota
    assign overLimit[c] = (int'(perClass[c]) > LIMITS[c]);
  end

endmodule

// File: rtl/vliw_hazard_matrix.sv
module vliw_hazard_matrix
  import vliw_chk_pkg::*;
#(
  parameter int NUM_SLOTS     = 23,
  parameter int ADDR_W        = 11,
  parameter int VLEN          = 8,
  parameter int SCRATCH_WORDS = 1536
) (
  input  logic [NUM_SLOTS-1:0]        slotValid,
  input  logic [NUM_SLOTS*CLS_W-1:0]  slotClass,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotDst,
  input  logic [NUM_SLOTS-1:0]        slotDstEn,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotSrcA,
  input  logic [NUM_SLOTS-1:0]        slotSrcAEn,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotSrcB,
  input  logic [NUM_SLOTS-1:0]        slotSrcBEn,
  output logic                        rawHit,
  output logic                        wawHit,
  output logic                        warHit,
  output logic                        addrBad
);

  int spanLen [NUM_SLOTS];
  int dBase   [NUM_SLOTS];
  int aBase   [NUM_SLOTS];
  int bBase   [NUM_SLOTS];

  function automatic logic spansMeet(input int xBase, input int xLen, input int yBase, input int yLen);
    return (xBase < yBase + yLen) && (yBase < xBase + xLen);
  endfunction

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unpack
    assign spanLen[g] = (slotClass[g*CLS_W +: CLS_W] == CLS_VALU) ? VLEN : 1;
    assign dBase[g]   = int'(slotDst[g*ADDR_W +: ADDR_W]);
    assign aBase[g]   = int'(slotSrcA[g*ADDR_W +: ADDR_W]);
    assign bBase[g]   = int'(slotSrcB[g*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    rawHit  = 1'b0;
    wawHit  = 1'b0;
    warHit  = 1'b0;
    addrBad = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slotValid[s]) begin
        if (slotDstEn[s]  && (dBase[s] + spanLen[s] > SCRATCH_WORDS)) addrBad = 1'b1;
        if (slotSrcAEn[s] && (aBase[s] + spanLen[s] > SCRATCH_WORDS)) addrBad = 1'b1;
        if (slotSrcBEn[s] && (bBase[s] + spanLen[s] > SCRATCH_WORDS)) addrBad = 1'b1;
      end
    end
    // i is the earlier slot, j the later one.
    for (int i = 0; i < NUM_SLOTS; i++) begin
      for (int j = i + 1; j < NUM_SLOTS; j++) begin
        if (slotValid[i] && slotValid[j]) begin
          if (slotDstEn[i]) begin
            if (slotSrcAEn[j] && spansMeet(dBase[i], spanLen[i], aBase[j], spanLen[j])) rawHit = 1'b1;
            if (slotSrcBEn[j] && spansMeet(dBase[i], spanLen[i], bBase[j], spanLen[j])) rawHit = 1'b1;
            if (slotDstEn[j]  && spansMeet(dBase[i], spanLen[i], dBase[j], spanLen[j])) wawHit = 1'b1;
          end
          if (slotDstEn[j]) begin
            if (slotSrcAEn[i] && spansMeet(aBase[i], spanLen[i], dBase[j], spanLen[j])) warHit = 1'b1;
            if (slotSrcBEn[i] && spansMeet(bBase[i], spanLen[i], dBase[j], spanLen[j])) warHit = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/vliw_check_ctrl.sv
module vliw_check_ctrl
  import vliw_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bundleValid,
  output chkStrobe_t strobe,
  output logic       resValid
);

  assign strobe.capture = bundleValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resValid <= 1'b0;
    else        resValid <= bundleValid;
  end

endmodule

// File: rtl/vliw_check_dp.sv
module vliw_check_dp
  import vliw_chk_pkg::*;
#(
  parameter int NUM_SLOTS     = 23,
  parameter int ADDR_W        = 11,
  parameter int VLEN          = 8,
  parameter int SCRATCH_WORDS = 1536,
  parameter int CNT_W         = 5,
  parameter int LIM_ALU       = 12,
  parameter int LIM_VALU      = 6,
  parameter int LIM_LOAD      = 2,
  parameter int LIM_STORE     = 2,
  parameter int LIM_FLOW      = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  chkStrobe_t                  strobe,
  input  logic                        resValid,
  input  logic [NUM_SLOTS-1:0]        slotValid,
  input  logic [NUM_SLOTS*CLS_W-1:0]  slotClass,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotDst,
  input  logic [NUM_SLOTS-1:0]        slotDstEn,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotSrcA,
  input  logic [NUM_SLOTS-1:0]        slotSrcAEn,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotSrcB,
  input  logic [NUM_SLOTS-1:0]        slotSrcBEn,
  output logic                        resAccept,
  output logic [NUM_CLASSES-1:0]      resOver,
  output logic                        resRaw,
  output logic                        resWaw,
  output logic                        resWar,
  output logic                        resBad,
  output logic [CNT_W-1:0]            resCount
);

  localparam int TOTAL_LIM = LIM_ALU + LIM_VALU + LIM_LOAD + LIM_STORE + LIM_FLOW;

  logic [CNT_W-1:0]       countNow;
  logic [NUM_CLASSES-1:0] overNow;
  logic                   classBadNow;
  logic                   rawNow, wawNow, warNow, addrBadNow;
  logic                   badNow, acceptNow;

  vliw_slot_counter #(
    .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W),
    .LIM_ALU(LIM_ALU), .LIM_VALU(LIM_VALU), .LIM_LOAD(LIM_LOAD),
    .LIM_STORE(LIM_STORE), .LIM_FLOW(LIM_FLOW)
  ) u_counter (
    .slotValid (slotValid),
    .slotClass (slotClass),
    .totalCount(countNow),
    .overLimit (overNow),
    .classBad  (classBadNow)
  );

  vliw_hazard_matrix #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .VLEN(VLEN), .SCRATCH_WORDS(SCRATCH_WORDS)
  ) u_hazard (
    .slotValid (slotValid),
    .slotClass (slotClass),
    .slotDst   (slotDst),
    .slotDstEn (slotDstEn),
    .slotSrcA  (slotSrcA),
    .slotSrcAEn(slotSrcAEn),
    .slotSrcB  (slotSrcB),
    .slotSrcBEn(slotSrcBEn),
    .rawHit    (rawNow),
    .wawHit    (wawNow),
    .warHit    (warNow),
    .addrBad   (addrBadNow)
  );

  assign badNow    = classBadNow | addrBadNow;
  assign acceptNow = ~(|overNow) & ~rawNow & ~wawNow & ~badNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resAccept <= 1'b0;
      resOver   <= '0;
      resRaw    <= 1'b0;
      resWaw    <= 1'b0;
      resWar    <= 1'b0;
      resBad    <= 1'b0;
      resCount  <= '0;
    end else if (strobe.capture) begin
      resAccept <= acceptNow;
      resOver   <= overNow;
      resRaw    <= rawNow;
      resWaw    <= wawNow;
      resWar    <= warNow;
      resBad    <= badNow;
      resCount  <= countNow;
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> $stable(resAccept) && $stable(resCount) && $stable(resOver)); // R2

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(resCount) <= NUM_SLOTS); // R3

  AST_OVER_NEEDS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && (resOver != '0) |-> resCount != '0); // R4

  AST_HAZARD_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && (resRaw || resWaw || resWar) |-> int'(resCount) >= 2); // R5

  AST_WAR_NOT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && resWar && !resRaw && !resWaw && !resBad && (resOver == '0) |-> resAccept); // R7

  AST_ACCEPT_WITHIN_QUOTA: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && resAccept |-> int'(resCount) <= TOTAL_LIM); // R11

endmodule

// File: rtl/vliw_bundle_check.sv
module vliw_bundle_check
  import vliw_chk_pkg::*;
#(
  parameter int NUM_SLOTS     = 23,
  parameter int ADDR_W        = 11,
  parameter int VLEN          = 8,
  parameter int SCRATCH_WORDS = 1536,
  parameter int LIM_ALU       = 12,
  parameter int LIM_VALU      = 6,
  parameter int LIM_LOAD      = 2,
  parameter int LIM_STORE     = 2,
  parameter int LIM_FLOW      = 1,
  localparam int CNT_W        = $clog2(NUM_SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bundleValid,
  input  logic [NUM_SLOTS-1:0]        slotValid,
  input  logic [NUM_SLOTS*CLS_W-1:0]  slotClass,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotDst,
  input  logic [NUM_SLOTS-1:0]        slotDstEn,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotSrcA,
  input  logic [NUM_SLOTS-1:0]        slotSrcAEn,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotSrcB,
  input  logic [NUM_SLOTS-1:0]        slotSrcBEn,
  output logic                        resValid,
  output logic                        accept,
  output logic [NUM_CLASSES-1:0]      overLimit,
  output logic                        rawHit,
  output logic                        wawHit,
  output logic                        warHit,
  output logic                        fieldBad,
  output logic [CNT_W-1:0]            opCount
);

  chkStrobe_t strobe;

  vliw_check_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bundleValid(bundleValid),
    .strobe     (strobe),
    .resValid   (resValid)
  );

  vliw_check_dp #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .VLEN(VLEN), .SCRATCH_WORDS(SCRATCH_WORDS),
    .CNT_W(CNT_W), .LIM_ALU(LIM_ALU), .LIM_VALU(LIM_VALU), .LIM_LOAD(LIM_LOAD),
    .LIM_STORE(LIM_STORE), .LIM_FLOW(LIM_FLOW)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .resValid  (resValid),
    .slotValid (slotValid),
    .slotClass (slotClass),
    .slotDst   (slotDst),
    .slotDstEn (slotDstEn),
    .slotSrcA  (slotSrcA),
    .slotSrcAEn(slotSrcAEn),
    .slotSrcB  (slotSrcB),
    .slotSrcBEn(slotSrcBEn),
    .resAccept (accept),
    .resOver   (overLimit),
    .resRaw    (rawHit),
    .resWaw    (wawHit),
    .resWar    (warHit),
    .resBad    (fieldBad),
    .resCount  (opCount)
  );

endmodule

// File: tb/vliw_bundle_check_tb.sv
module vliw_bundle_check_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int AW = 11;
  localparam int CW = 3;
  localparam int KW = $clog2(NS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bundleValid = 1'b0;
  logic [NS-1:0]    slotValid = '0;
  logic [NS*CW-1:0] slotClass = '0;
  logic [NS*AW-1:0] slotDst = '0;
  logic [NS-1:0]    slotDstEn = '0;
  logic [NS*AW-1:0] slotSrcA = '0;
  logic [NS-1:0]    slotSrcAEn = '0;
  logic [NS*AW-1:0] slotSrcB = '0;
  logic [NS-1:0]    slotSrcBEn = '0;
  logic resValid, accept, rawHit, wawHit, warHit, fieldBad;
  logic [4:0]    overLimit;
  logic [KW-1:0] opCount;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  typedef struct {
    bit       acc;
    bit [4:0] ov;
    bit       raw, waw, war, bad;
    int       cnt;
    string    tag;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vliw_bundle_check #(.NUM_SLOTS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bundleValid(bundleValid),
    .slotValid(slotValid), .slotClass(slotClass), .slotDst(slotDst), .slotDstEn(slotDstEn),
    .slotSrcA(slotSrcA), .slotSrcAEn(slotSrcAEn), .slotSrcB(slotSrcB), .slotSrcBEn(slotSrcBEn),
    .resValid(resValid), .accept(accept), .overLimit(overLimit), .rawHit(rawHit),
    .wawHit(wawHit), .warHit(warHit), .fieldBad(fieldBad), .opCount(opCount)
  );

  task automatic clearSlots();
    slotValid = '0; slotClass = '0; slotDst = '0; slotDstEn = '0;
    slotSrcA = '0; slotSrcAEn = '0; slotSrcB = '0; slotSrcBEn = '0;
  endtask

  task automatic setOp(input int i, input int cls, input int dst, input bit dEn,
                       input int sa, input bit aEn, input int sb, input bit bEn);
    slotValid[i] = 1'b1;
    slotClass[i*CW +: CW] = CW'(cls);
    slotDst[i*AW +: AW] = AW'(dst);  slotDstEn[i] = dEn;
    slotSrcA[i*AW +: AW] = AW'(sa);  slotSrcAEn[i] = aEn;
    slotSrcB[i*AW +: AW] = AW'(sb);  slotSrcBEn[i] = bEn;
  endtask

  // Called at a negedge; presents the bundle for one clock.
  task automatic send(input bit acc, input bit [4:0] ov, input bit raw, input bit waw,
                      input bit war, input bit bad, input int cnt, input string tag);
    expItem_t e;
    e.acc = acc; e.ov = ov; e.raw = raw; e.waw = waw; e.war = war; e.bad = bad;
    e.cnt = cnt; e.tag = tag;
    expQ.push_back(e);
    bundleValid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    bundleValid = 1'b0;
    clearSlots();
    repeat (n) @(negedge clk);
  endtask

  task automatic checkVal(input bit ok, input string tag, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Monitor: compare each result against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && resValid) begin
      if (expQ.size() == 0) begin
        checkVal(1'b0, "R2 unexpected result", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        compared++;
        if (accept !== e.acc || overLimit !== e.ov || rawHit !== e.raw || wawHit !== e.waw ||
            warHit !== e.war || fieldBad !== e.bad || int'(opCount) != e.cnt) begin
          mismatched++;
          $display("FAIL %s actual acc=%0b ov=%05b raw=%0b waw=%0b war=%0b bad=%0b cnt=%0d expected acc=%0b ov=%05b raw=%0b waw=%0b war=%0b bad=%0b cnt=%0d",
                   e.tag, accept, overLimit, rawHit, wawHit, warHit, fieldBad, opCount,
                   e.acc, e.ov, e.raw, e.waw, e.war, e.bad, e.cnt);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checkVal(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkVal(resValid == 0 && accept == 0 && overLimit == 0 && rawHit == 0 && wawHit == 0 &&
             warHit == 0 && fieldBad == 0 && opCount == 0, "R1 reset state",
             int'({resValid, accept, overLimit, rawHit, wawHit, warHit, fieldBad}), 0);

    // R3 empty bundle
    clearSlots(); send(1, 5'b0, 0, 0, 0, 0, 0, "R3 empty bundle");
    // R8 shared sources
    clearSlots();
    for (int i = 0; i < 3; i++) setOp(i, 0, 10 + i, 1, 3, 1, 4, 1);
    send(1, 5'b0, 0, 0, 0, 0, 3, "R8 shared sources");
    // R8 own source equals own destination
    clearSlots(); setOp(0, 0, 5, 1, 5, 1, 0, 0);
    send(1, 5'b0, 0, 0, 0, 0, 1, "R8 self read-write");
    // R4 ALU quota edge
    clearSlots(); for (int i = 0; i < 12; i++) setOp(i, 0, 100 + i, 1, 0, 0, 0, 0);
    send(1, 5'b0, 0, 0, 0, 0, 12, "R4 twelve scalar ok");
    clearSlots(); for (int i = 0; i < 13; i++) setOp(i, 0, 100 + i, 1, 0, 0, 0, 0);
    send(0, 5'b00001, 0, 0, 0, 0, 13, "R4 thirteen scalar");
    clearSlots(); for (int i = 0; i < 7; i++) setOp(i, 1, 300 + 8*i, 1, 0, 0, 0, 0);
    send(0, 5'b00010, 0, 0, 0, 0, 7, "R4 seven vector");
    clearSlots(); for (int i = 0; i < 3; i++) setOp(i, 2, 400 + i, 1, 0, 0, 0, 0);
    send(0, 5'b00100, 0, 0, 0, 0, 3, "R4 three loads");
    clearSlots(); for (int i = 0; i < 3; i++) setOp(i, 3, 0, 0, 3, 1, 0, 0);
    send(0, 5'b01000, 0, 0, 0, 0, 3, "R4 three stores");
    clearSlots(); for (int i = 0; i < 2; i++) setOp(i, 4, 0, 0, 0, 0, 0, 0);
    send(0, 5'b10000, 0, 0, 0, 0, 2, "R4 two flow");
    // R5 read after write
    clearSlots(); setOp(0, 0, 50, 1, 0, 0, 0, 0); setOp(1, 0, 60, 1, 50, 1, 0, 0);
    send(0, 5'b0, 1, 0, 0, 0, 2, "R5 later reads earlier write");
    // R7 write after read, accepted
    clearSlots(); setOp(0, 0, 71, 1, 0, 0, 70, 1); setOp(1, 0, 70, 1, 0, 0, 0, 0);
    send(1, 5'b0, 0, 0, 1, 0, 2, "R7 war only");
    // R6 write after write
    clearSlots(); setOp(0, 0, 80, 1, 0, 0, 0, 0); setOp(1, 0, 80, 1, 0, 0, 0, 0);
    send(0, 5'b0, 0, 1, 0, 0, 2, "R6 double write");
    // R3 invalid slots and disabled operands ignored
    clearSlots();
    setOp(0, 0, 90, 1, 0, 0, 0, 0);
    setOp(1, 0, 90, 1, 90, 1, 0, 0);
    setOp(2, 0, 91, 1, 90, 0, 92, 1);
    for (int i = 3; i < 6; i++) setOp(i, 2, 600 + i, 1, 0, 0, 0, 0);
    slotValid[1] = 1'b0; slotValid[3] = 1'b0; slotValid[4] = 1'b0; slotValid[5] = 1'b0;
    send(1, 5'b0, 0, 0, 0, 0, 2, "R3 invalid slot ignored");
    // R9 vector spans
    clearSlots(); setOp(0, 1, 200, 1, 0, 1, 8, 1); setOp(1, 0, 20, 1, 207, 1, 0, 0);
    send(0, 5'b0, 1, 0, 0, 0, 2, "R9 span last word read");
    clearSlots(); setOp(0, 1, 200, 1, 0, 0, 0, 0); setOp(1, 0, 21, 1, 208, 1, 0, 0);
    send(1, 5'b0, 0, 0, 0, 0, 2, "R9 word past span");
    clearSlots(); setOp(0, 1, 500, 1, 192, 1, 0, 0); setOp(1, 0, 199, 1, 0, 0, 0, 0);
    send(1, 5'b0, 0, 0, 1, 0, 2, "R9 war on vector source");
    // R10 field checks
    clearSlots(); setOp(0, 0, 1536, 1, 0, 0, 0, 0);
    send(0, 5'b0, 0, 0, 0, 1, 1, "R10 address 1536");
    clearSlots(); setOp(0, 1, 1528, 1, 0, 0, 0, 0);
    send(1, 5'b0, 0, 0, 0, 0, 1, "R10 vector ends at 1535");
    clearSlots(); setOp(0, 1, 0, 0, 1529, 1, 0, 0);
    send(0, 5'b0, 0, 0, 0, 1, 1, "R10 vector past top");
    clearSlots(); setOp(0, 5, 0, 0, 0, 0, 0, 0);
    send(0, 5'b0, 0, 0, 0, 1, 1, "R10 class code 5");
    // R11 combined: war plus waw rejects
    clearSlots(); setOp(0, 0, 30, 1, 31, 1, 0, 0); setOp(1, 0, 30, 1, 0, 0, 0, 0);
    setOp(2, 0, 31, 1, 0, 0, 0, 0);
    send(0, 5'b0, 0, 1, 1, 0, 3, "R11 waw with war");
    // R2 back-to-back then hold
    clearSlots(); setOp(0, 0, 50, 1, 0, 0, 0, 0); setOp(1, 0, 60, 1, 50, 1, 0, 0);
    send(0, 5'b0, 1, 0, 0, 0, 2, "R2 back-to-back first");
    clearSlots(); setOp(0, 2, 7, 1, 0, 0, 0, 0);
    send(1, 5'b0, 0, 0, 0, 0, 1, "R2 back-to-back second");
    idle(4);
    checkVal(resValid == 0, "R2 idle resValid", int'(resValid), 0);
    checkVal(accept == 1 && opCount == 1, "R2 hold accept", int'(accept), 1);
    clearSlots(); setOp(0, 0, 80, 1, 0, 0, 0, 0); setOp(1, 0, 80, 1, 0, 0, 0, 0);
    send(0, 5'b0, 0, 1, 0, 0, 2, "R2 reject before hold");
    idle(3);
    checkVal(accept == 0 && wawHit == 1, "R2 hold reject", int'(accept), 0);
    checkVal(expQ.size() == 0, "R2 all results seen", expQ.size(), 0);
    finishRun();
  end

endmodule